// File: doc/BRIEF.md
# Colour Correction Matrix Engine

This block sits in a pixel pipeline and multiplies every RGB pixel by a programmable 3x3 gain matrix. Each output channel is formed from all three input channels, each weighted by its own coefficient. The weighted sum is then rounded and clamped to the pixel code range. A relay setting lets pixels through unchanged with the same timing. The stream is stopped while the block is disabled.

Software programs the block through a 32-bit register port. The port holds a global enable, a configuration word, a frame-size word and nine coefficients. Configuration and coefficient writes go into pending copies. The active copies take them over when a start-of-frame pixel is accepted, so the matrix never changes partway through a frame.

Pixels arrive and leave on a valid/ready stream. Each pixel carries a start-of-frame flag and an end-of-line flag. The datapath is a three-stage pipeline, and one shared advance signal stalls all three stages together.

Top module: `ccm_engine`

## Requirements
- R1: After reset, `s_ready_o` and `m_valid_o` are low, and every register reads zero.
- R2: Register map:
  - 0x00: bit 0 is the enable.
  - 0x20: bits 3:0 are the configuration. Bit 0 is relay, bit 1 is matrix enable, bits 2 and 3 are stored only.
  - 0x30: a full 32-bit word, height in bits 31:16 and width in bits 15:0.
  - 0x80, 0x84, 0x88, 0x8C and 0x90: coefficients. Coefficient 2n sits in bits 27:16 of register 0x80+4n, and coefficient 2n+1 sits in bits 11:0.
  - Coefficient 8 has only an upper half. Bits that are not implemented read as zero.
- R3: While the enable bit is clear, `s_ready_o` and `m_valid_o` stay low. Pixels already in the pipeline are held and come out intact once the block is enabled again.
- R4: A coefficient is 12-bit sign-magnitude. Bit 11 is the sign, and bits 10:0 are the magnitude with 10 fraction bits. 0x400 is unity gain, 0x7FF is the largest gain, and 0xC00 is -1.
- R5: The matrix is applied row by row. Coefficients 0-2 produce R, 3-5 produce G and 6-8 produce B. Within each row the weights apply to the R, G and B inputs in that order. Pixel packing is R in `[3*PIX_W-1:2*PIX_W]`, G in the middle and B in the low bits.
- R6: Products are kept at full precision and summed as signed values. The sum gets 2^9 added, is shifted arithmetically right by 10, and is then clamped to the range 0 to 2^PIX_W-1.
- R7: The matrix is applied only when configuration bit 1 is set and bit 0 is clear. In every other case the pixel passes through bit-exact. Bits 2 and 3 have no effect on pixels.
- R8: Configuration and coefficient writes take effect from the next accepted start-of-frame pixel, and that pixel already uses them. Writes made mid-frame do not affect the frame in progress.
- R9: While the output is always ready, a pixel accepted at one clock edge appears at the output after the third edge. Its frame and line flags travel with it.
- R10: When `m_valid_o` is high and `m_ready_i` is low:
  - the output data and flags hold;
  - `s_ready_o` is low;
  - no pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (pending copy) |
| s_valid_i | input | 1 | Input pixel valid |
| s_ready_o | output | 1 | Input pixel accepted |
| s_sof_i | input | 1 | Input start of frame |
| s_eol_i | input | 1 | Input end of line |
| s_rgb_i | input | 3*PIX_W | Input pixel, R high, B low |
| m_valid_o | output | 1 | Output pixel valid |
| m_ready_i | input | 1 | Downstream ready |
| m_sof_o | output | 1 | Output start of frame |
| m_eol_o | output | 1 | Output end of line |
| m_rgb_o | output | 3*PIX_W | Output pixel |

## Verification
The assertions check several properties on every cycle:
- the enable gating of both handshakes;
- the stability of output data and flags under back-pressure;
- the coupling of input ready to output stall;
- that the active matrix changes only on an accepted start-of-frame.

Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural model. These cover:
- the numeric result: sign-magnitude weighting, row order, rounding and clamping;
- the relay and mode combinations;
- the exact three-cycle latency;
- that a mid-frame coefficient write is deferred to the next frame.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int REG_W  = 32;
  localparam int COEF_W = 12;
  localparam int FRAC_W = 10;
  localparam int NCH    = 3;
  localparam int NCOEF  = NCH * NCH;

  localparam int ADDR_EN    = 'h00;
  localparam int ADDR_CFG   = 'h20;
  localparam int ADDR_SIZE  = 'h30;
  localparam int ADDR_COEF0 = 'h80;

  typedef logic [COEF_W-1:0] coef_t;

  // bit 0 relay, bit 1 matrix enable, bits 2/3 stored only
  typedef struct packed {
    logic clip_src;
    logic gamma_off;
    logic engine;
    logic relay;
  } cfg_t;
endpackage

// File: rtl/ccm_regs.sv
module ccm_regs
  import ccm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  input  logic                    load_i,
  output logic                    en_o,
  output logic                    mat_o,
  output coef_t [NCOEF-1:0]       coef_o,
  output coef_t [NCOEF-1:0]       act_coef_o
);
  localparam int CFG_W = $bits(cfg_t);

  function automatic logic [AW-1:0] coef_addr(input int k);
    return AW'(ADDR_COEF0 + 4 * (k / 2));
  endfunction

  logic             en_q;
  cfg_t             cfg_pend, cfg_act, cfg_eff;
  logic [REG_W-1:0] size_q;
  coef_t [NCOEF-1:0] coef_pend, coef_pend_d, coef_act;

  always_comb begin
    coef_pend_d = coef_pend;
    for (int k = 0; k < NCOEF; k++) begin
      if (we_i && addr_i == coef_addr(k))
        coef_pend_d[k] = (k % 2 == 0) ? wdata_i[16 +: COEF_W] : wdata_i[0 +: COEF_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      cfg_pend  <= '0;
      cfg_act   <= '0;
      size_q    <= '0;
      coef_pend <= '0;
      coef_act  <= '0;
    end else begin
      coef_pend <= coef_pend_d;
      if (we_i && addr_i == AW'(ADDR_EN))   en_q     <= wdata_i[0];
      if (we_i && addr_i == AW'(ADDR_CFG))  cfg_pend <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (we_i && addr_i == AW'(ADDR_SIZE)) size_q   <= wdata_i;
      if (load_i) begin
        cfg_act  <= cfg_pend;
        coef_act <= coef_pend;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_EN))   rdata_o[0] = en_q;
    if (addr_i == AW'(ADDR_CFG))  rdata_o[CFG_W-1:0] = cfg_pend;
    if (addr_i == AW'(ADDR_SIZE)) rdata_o = size_q;
    for (int k = 0; k < NCOEF; k++) begin
      if (addr_i == coef_addr(k))
        rdata_o[((k % 2 == 0) ? 16 : 0) +: COEF_W] = coef_pend[k];
    end
  end

  // start-of-frame pixel already sees the pending set
  assign cfg_eff    = load_i ? cfg_pend  : cfg_act;
  assign coef_o     = load_i ? coef_pend : coef_act;
  assign mat_o      = cfg_eff.engine & ~cfg_eff.relay;
  assign en_o       = en_q;
  assign act_coef_o = coef_act;
endmodule

// File: rtl/ccm_datapath.sv
module ccm_datapath
  import ccm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  logic                   in_valid_i,
  input  logic                   in_sof_i,
  input  logic                   in_eol_i,
  input  logic [NCH*PIX_W-1:0]   in_rgb_i,
  input  logic                   mat_i,
  input  coef_t [NCOEF-1:0]      coef_i,
  output logic                   out_valid_o,
  output logic                   out_sof_o,
  output logic                   out_eol_o,
  output logic [NCH*PIX_W-1:0]   out_rgb_o
);
  localparam int PX_W    = NCH * PIX_W;
  localparam int MAG_W   = COEF_W - 1;
  localparam int PROD_W  = PIX_W + MAG_W + 1;
  localparam int SUM_W   = PROD_W + 2;
  localparam int HALF    = 1 << (FRAC_W - 1);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  typedef struct packed {
    logic            valid;
    logic            sof;
    logic            eol;
    logic            mat;
    logic [PX_W-1:0] raw;
  } tag_t;

  tag_t t_in, t1, t2, t3;
  logic signed [PROD_W-1:0] prod_d [NCOEF];
  logic signed [PROD_W-1:0] prod_q [NCOEF];
  logic signed [SUM_W-1:0]  sum_d  [NCH];
  logic signed [SUM_W-1:0]  sum_q  [NCH];
  logic [PX_W-1:0]          px_d, px_q;

  assign t_in = '{valid: in_valid_i, sof: in_sof_i, eol: in_eol_i, mat: mat_i, raw: in_rgb_i};

  // stage 1: nine sign-magnitude products
  always_comb begin
    logic [PROD_W-1:0] mag;
    for (int k = 0; k < NCOEF; k++) begin
      mag = PROD_W'(in_rgb_i[(NCH-1-(k % NCH))*PIX_W +: PIX_W]) * PROD_W'(coef_i[k][MAG_W-1:0]);
      prod_d[k] = coef_i[k][COEF_W-1] ? -$signed(mag) : $signed(mag);
    end
  end

  // stage 2: row sums
  always_comb begin
    for (int r = 0; r < NCH; r++)
      sum_d[r] = SUM_W'(prod_q[NCH*r]) + SUM_W'(prod_q[NCH*r+1]) + SUM_W'(prod_q[NCH*r+2]);
  end

  // stage 3: round half up, drop fraction, clamp
  always_comb begin
    logic signed [SUM_W-1:0] t;
    for (int r = 0; r < NCH; r++) begin
      t = (sum_q[r] + SUM_W'(HALF)) >>> FRAC_W;
      if (t < 0)                       px_d[(NCH-1-r)*PIX_W +: PIX_W] = '0;
      else if (t > SUM_W'(PIX_MAX))    px_d[(NCH-1-r)*PIX_W +: PIX_W] = PIX_W'(PIX_MAX);
      else                             px_d[(NCH-1-r)*PIX_W +: PIX_W] = t[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1   <= '0;
      t2   <= '0;
      t3   <= '0;
      px_q <= '0;
      for (int k = 0; k < NCOEF; k++) prod_q[k] <= '0;
      for (int r = 0; r < NCH; r++)   sum_q[r]  <= '0;
    end else if (adv_i) begin
      t1   <= t_in;
      t2   <= t1;
      t3   <= t2;
      px_q <= px_d;
      for (int k = 0; k < NCOEF; k++) prod_q[k] <= prod_d[k];
      for (int r = 0; r < NCH; r++)   sum_q[r]  <= sum_d[r];
    end
  end

  assign out_valid_o = t3.valid;
  assign out_sof_o   = t3.sof;
  assign out_eol_o   = t3.eol;
  assign out_rgb_o   = t3.mat ? px_q : t3.raw;
endmodule

// File: rtl/ccm_engine.sv
module ccm_engine
  import ccm_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int AW    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic                 s_valid_i,
  output logic                 s_ready_o,
  input  logic                 s_sof_i,
  input  logic                 s_eol_i,
  input  logic [3*PIX_W-1:0]   s_rgb_i,
  output logic                 m_valid_o,
  input  logic                 m_ready_i,
  output logic                 m_sof_o,
  output logic                 m_eol_o,
  output logic [3*PIX_W-1:0]   m_rgb_o
);
  logic              en, mat, adv, load, dp_valid;
  coef_t [NCOEF-1:0] coef_eff, act_coef;

  // one advance for all stages; frozen while disabled
  assign adv       = en & (~dp_valid | m_ready_i);
  assign s_ready_o = adv;
  assign load      = s_valid_i & adv & s_sof_i;
  assign m_valid_o = en & dp_valid;

  ccm_regs #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .load_i     (load),
    .en_o       (en),
    .mat_o      (mat),
    .coef_o     (coef_eff),
    .act_coef_o (act_coef)
  );

  ccm_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .in_valid_i  (s_valid_i),
    .in_sof_i    (s_sof_i),
    .in_eol_i    (s_eol_i),
    .in_rgb_i    (s_rgb_i),
    .mat_i       (mat),
    .coef_i      (coef_eff),
    .out_valid_o (dp_valid),
    .out_sof_o   (m_sof_o),
    .out_eol_o   (m_eol_o),
    .out_rgb_o   (m_rgb_o)
  );
endmodule

// File: rtl/ccm_engine_chk.sv
module ccm_engine_chk
  import ccm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               load_i,
  input coef_t [NCOEF-1:0]  act_coef_i,
  input logic               s_ready_i,
  input logic               m_valid_i,
  input logic               m_ready_i,
  input logic               m_sof_i,
  input logic               m_eol_i,
  input logic [3*PIX_W-1:0] m_rgb_i
);
  // R3
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!s_ready_i && !m_valid_i));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_i && !m_ready_i) |=> ($stable(m_rgb_i) && $stable(m_sof_i) && $stable(m_eol_i)));

  // R10
  in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_i && !m_ready_i) |-> !s_ready_i);

  // R8
  shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_coef_i));
endmodule

bind ccm_engine ccm_engine_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en),
  .load_i     (load),
  .act_coef_i (act_coef),
  .s_ready_i  (s_ready_o),
  .m_valid_i  (m_valid_o),
  .m_ready_i  (m_ready_i),
  .m_sof_i    (m_sof_o),
  .m_eol_i    (m_eol_o),
  .m_rgb_i    (m_rgb_o)
);

// File: tb/ccm_engine_tb.sv
module ccm_engine_tb;
  localparam int PIX_W = 8;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        s_valid_i = 1'b0, s_sof_i = 1'b0, s_eol_i = 1'b0;
  logic [23:0] s_rgb_i = '0;
  logic        s_ready_o, m_valid_o, m_sof_o, m_eol_o;
  logic        m_ready_i = 1'b1;
  logic [23:0] m_rgb_o;

  int    n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
  bit    lat_mode = 0;
  string cur_req = "R1";

  logic [25:0] exp_q[$];
  int          acc_q[$];
  logic [8:0][11:0] pend_c = '0, act_c = '0;
  logic [3:0]  pend_cfg = '0, act_cfg = '0;

  always #10 clk = ~clk;

  ccm_engine #(.PIX_W(PIX_W), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_sof_i(s_sof_i), .s_eol_i(s_eol_i), .s_rgb_i(s_rgb_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_sof_o(m_sof_o), .m_eol_o(m_eol_o), .m_rgb_o(m_rgb_o)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // behavioural reference: sign-magnitude weights, round half up, clamp
  function automatic logic [23:0] ref_px(input logic [23:0] p, input logic [8:0][11:0] c, input bit mat);
    logic [23:0] o;
    int acc, v, w;
    if (!mat) return p;
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int k = 0; k < 3; k++) begin
        v = int'(p[(2-k)*8 +: 8]);
        w = int'(c[3*r+k][10:0]);
        if (c[3*r+k][11]) acc -= v * w; else acc += v * w;
      end
      acc = (acc + 512) >>> 10;
      if (acc < 0) acc = 0;
      if (acc > 255) acc = 255;
      o[(2-r)*8 +: 8] = acc[7:0];
    end
    return o;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: m_ready_i = 1'b1;
      1: m_ready_i = ($urandom % 3) != 0;
      default: m_ready_i = 1'b0;
    endcase
  end

  // monitor and model
  always @(negedge clk) if (rst_n) begin
    if (m_valid_o && m_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected output", {8'h0, m_rgb_o}, 32'h0);
      else begin
        logic [25:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        chk({m_sof_o, m_eol_o, m_rgb_o} == e, "pixel/flags", {6'h0, m_sof_o, m_eol_o, m_rgb_o}, {6'h0, e});
        if (lat_mode) chk(cyc - a == 3, "latency", cyc - a, 3);
      end
    end
    if (s_valid_i && s_ready_o) begin
      if (s_sof_i) begin act_c = pend_c; act_cfg = pend_cfg; end
      exp_q.push_back({s_sof_i, s_eol_i, ref_px(s_rgb_i, act_c, act_cfg[1] & ~act_cfg[0])});
      acc_q.push_back(cyc);
    end
    if (reg_we_i) begin
      if (reg_addr_i == 8'h20) pend_cfg = reg_wdata_i[3:0];
      for (int k = 0; k < 9; k++)
        if (reg_addr_i == 8'(8'h80 + 4 * (k / 2)))
          pend_c[k] = (k % 2 == 0) ? reg_wdata_i[27:16] : reg_wdata_i[11:0];
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #2;
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e);
    @(posedge clk); #2;
    reg_addr_i = a;
    @(negedge clk);
    chk(reg_rdata_o == e, $sformatf("read 0x%02h", a), reg_rdata_o, e);
  endtask

  // caller is aligned at posedge+2
  task automatic send(input logic [23:0] p, input bit sof, input bit eol);
    s_valid_i = 1'b1; s_rgb_i = p; s_sof_i = sof; s_eol_i = eol;
    do @(negedge clk); while (!s_ready_o);
    @(posedge clk); #2;
    s_valid_i = 1'b0; s_sof_i = 1'b0; s_eol_i = 1'b0;
  endtask

  task automatic frame(input int h, input int w);
    @(posedge clk); #2;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        send(24'($urandom), (x == 0 && y == 0), (x == w - 1));
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "drain", exp_q.size(), 0);
  endtask

  task automatic load_coefs(input logic [8:0][11:0] c);
    for (int n = 0; n < 5; n++)
      wr(8'(8'h80 + 4 * n), {4'h0, c[2*n], 4'h0, (2*n+1 < 9) ? c[(2*n+1) % 9] : 12'h0});
  endtask

  task automatic rand_coefs();
    logic [8:0][11:0] c;
    for (int k = 0; k < 9; k++) c[k] = 12'($urandom);
    load_coefs(c);
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired: got %0d expected 0 pending", exp_q.size());
    finish_sim();
  end

  initial begin
    logic [8:0][11:0] c;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1
    cur_req = "R1";
    @(negedge clk);
    chk(!s_ready_o && !m_valid_o, "handshake idle", {s_ready_o, m_valid_o}, 0);
    rd_chk(8'h00, 0); rd_chk(8'h20, 0); rd_chk(8'h30, 0);
    for (int n = 0; n < 5; n++) rd_chk(8'(8'h80 + 4 * n), 0);

    // R2
    cur_req = "R2";
    wr(8'h30, 32'h0438_0780);  rd_chk(8'h30, 32'h0438_0780);
    wr(8'h20, 32'hFFFF_FFF4);  rd_chk(8'h20, 32'h4);
    wr(8'h80, 32'hF123_FABC);  rd_chk(8'h80, 32'h0123_0ABC);
    wr(8'h90, 32'hFFFF_FFFF);  rd_chk(8'h90, 32'h0FFF_0000);
    wr(8'h00, 32'hFFFF_FFFF);  rd_chk(8'h00, 32'h1);

    // R7: neither relay nor engine -> passthrough
    cur_req = "R7";
    wr(8'h20, 32'h0);
    frame(2, 4); drain();

    // R4 R5: identity then channel rotation
    cur_req = "R4";
    c = '0; c[0] = 12'h400; c[4] = 12'h400; c[8] = 12'h400;
    load_coefs(c); wr(8'h20, 32'h2);
    frame(2, 4); drain();
    cur_req = "R5";
    c = '0; c[1] = 12'h400; c[5] = 12'h400; c[6] = 12'h400;
    load_coefs(c);
    frame(2, 4); drain();

    // R6: half gain, negative unity, max gain clamp
    cur_req = "R6";
    c = '0; c[0] = 12'h200; c[3] = 12'hC00; c[6] = 12'h7FF; c[7] = 12'h7FF; c[8] = 12'h7FF;
    load_coefs(c);
    @(posedge clk); #2;
    send(24'h01_40_FF, 1, 0);
    send(24'h03_00_10, 0, 0);
    send(24'hFF_FF_FF, 0, 1);
    drain();
    for (int f = 0; f < 4; f++) begin rand_coefs(); frame(2, 5); drain(); end

    // R7: relay wins over engine; bits 2/3 inert
    cur_req = "R7";
    rand_coefs();
    wr(8'h20, 32'h3); frame(1, 6); drain();
    wr(8'h20, 32'hE); frame(1, 6); drain();
    wr(8'h20, 32'h1); frame(1, 6); drain();

    // R8: mid-frame write deferred
    cur_req = "R8";
    wr(8'h20, 32'h2); rand_coefs();
    @(posedge clk); #2;
    send(24'h102030, 1, 0); send(24'h405060, 0, 0);
    rand_coefs(); wr(8'h20, 32'h1);
    send(24'h708090, 0, 0); send(24'hA0B0C0, 0, 1);
    drain();
    frame(1, 4); drain();

    // R9
    cur_req = "R9";
    wr(8'h20, 32'h2); rdy_mode = 0; lat_mode = 1;
    @(posedge clk); #2;
    send(24'h55AA33, 1, 1); drain();
    frame(2, 3); drain();
    lat_mode = 0;

    // R10
    cur_req = "R10";
    rdy_mode = 1;
    for (int f = 0; f < 6; f++) begin rand_coefs(); frame(3, 7); drain(); end
    rdy_mode = 0;

    // R3
    cur_req = "R3";
    rdy_mode = 2;
    @(posedge clk); #2;
    send(24'h123456, 1, 0); send(24'h654321, 0, 1);
    wr(8'h00, 32'h0);
    rdy_mode = 0;
    @(posedge clk); #2;
    s_valid_i = 1'b1; s_rgb_i = 24'hDEADBE; s_sof_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!m_valid_o && !s_ready_o, "disabled handshake", {s_ready_o, m_valid_o}, 0);
    end
    @(posedge clk); #2;
    s_valid_i = 1'b0; s_sof_i = 1'b0;
    wr(8'h00, 32'h1);
    drain();

    finish_sim();
  end
endmodule